// File: doc/BRIEF.md
# Chebyshev Model Inverting Linearizer

This block corrects the static nonlinearity of a converter whose dither has already been removed by averaging. Each incoming value `y` is treated as the output of a stored transfer-curve model `h`. The block solves `h(x) = y` for `x` and emits `x` as the corrected sample. The model is a sum of Chebyshev polynomials of the first kind. Its coefficients sit in a small register file that the host writes, and a configurable order sets how many of them take part.

The inversion uses constant-slope Newton steps. The first estimate is `y` itself. Each step subtracts `(h(x) - y)` scaled by a stored reciprocal of the nominal slope `G`, so the step needs no divider. The Chebyshev sum is built with the three-term recurrence, one term per clock. One or two steps are run, as configured, and there is no convergence test. Samples enter and leave over valid/ready handshakes. One sample is processed at a time, so results come out in input order.

Top module: `cheb_linearizer`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A write with `coef_we` high stores `coef_wdata` at entry `coef_addr`. Entry k holds coefficient c_k as a signed value with W-2 fraction bits (16384 is 1.0 when W=16). All entries reset to 0.
- R3: Samples are signed with W-1 fraction bits, covering -1 to just under +1. The first estimate is the input itself. With c1 = 1.0 and every other used coefficient 0, the output equals the input exactly.
- R4: h(x) = sum over k = 0..order of floor(c_k*T_k / 2^(W-2)), accumulated in W+8 bits. T_0 = 2^(W-1) and T_1 = x. For higher k, T_k = floor(x*T_(k-1) / 2^(W-2)) - T_(k-2), wrapped to W+2 bits. Coefficients above the order have no effect.
- R5: One step computes e = h(x) - y and x_next = x - floor(e*R / 2^(W-2)). R is `cfg_recip`, a signed value with W-2 fraction bits that stands for 1/G.
- R6: `cfg_two_iter` = 0 runs one step and 1 runs two. The second step starts from the result of the first.
- R7: A step result above 2^(W-1)-1 becomes 2^(W-1)-1. A result below -2^(W-1) becomes -2^(W-1).
- R8: `out_valid` rises exactly steps*(order+2) clock edges after the edge that accepts the sample.
- R9: `in_ready` is 0 from acceptance until the result is taken. `out_valid` and `out_data` hold steady while `out_ready` is low. A taken result makes `in_ready` 1 again on the next cycle.
- R10: `cfg_order`, `cfg_two_iter` and `cfg_recip` are captured when a sample is accepted. Changing them while that sample is in flight has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | W | Averaged measured value y |
| out_valid | output | 1 | Corrected sample available |
| out_ready | input | 1 | Consumer takes the corrected sample |
| out_data | output | W | Corrected value x |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | $clog2(MAX_ORDER+1) | Coefficient index k |
| coef_wdata | input | W | Coefficient value |
| cfg_order | input | $clog2(MAX_ORDER+1) | Highest polynomial index used |
| cfg_two_iter | input | 1 | 0 runs one step, 1 runs two |
| cfg_recip | input | W | Reciprocal of the nominal slope |

## Verification
The bench uses the defaults W=16 and MAX_ORDER=7. With these it can fill the whole coefficient file and run the full-length recurrence at order 7. It can also reach order 0, where only the constant term is summed. The 16-bit sample width lets the bench drive both full-scale corners and force clamping in each direction with modest offset coefficients. The bench's integer model computes each expected result independently of the RTL, and every result is checked bit for bit against it.

// File: rtl/cheb_lin_pkg.sv
package cheb_lin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_STEP = 2'd2,
    ST_OUT  = 2'd3
  } lin_state_e;
endpackage

// File: rtl/cheb_coef_store.sv
module cheb_coef_store #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int IW    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IW-1:0]       waddr,
  input  logic signed [W-1:0] wdata,
  input  logic [IW-1:0]       raddr,
  output logic signed [W-1:0] rdata
);
  logic signed [W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic wr_en;
    assign wr_en = we && (waddr == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (wr_en) begin
        mem[g] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (raddr == IW'(i)) rdata = mem[i];
    end
  end
endmodule

// File: rtl/cheb_term_unit.sv
module cheb_term_unit #(
  parameter int W  = 16,
  parameter int TW = 18,
  parameter int AW = 24
) (
  input  logic signed [W-1:0]  u,
  input  logic signed [TW-1:0] t_cur,
  input  logic signed [TW-1:0] t_prev,
  input  logic                 first,
  input  logic signed [W-1:0]  coef,
  output logic signed [AW-1:0] term,
  output logic signed [TW-1:0] t_next
);
  localparam int F  = W - 1;
  localparam int CF = W - 2;
  localparam int PW = W + TW;

  logic signed [PW-1:0] prod_c, sh_c;
  logic signed [PW-1:0] prod_u, sh_u, diff;

  assign prod_c = coef * t_cur;
  assign sh_c   = prod_c >>> CF;
  assign term   = sh_c[AW-1:0];

  // 2*u*T >> F is the same floor as u*T >> (F-1)
  assign prod_u = u * t_cur;
  assign sh_u   = prod_u >>> (F - 1);
  assign diff   = sh_u - {{W{t_prev[TW-1]}}, t_prev};
  assign t_next = first ? {{(TW-W){u[W-1]}}, u} : diff[TW-1:0];
endmodule

// File: rtl/cheb_newton_step.sv
module cheb_newton_step #(
  parameter int W  = 16,
  parameter int AW = 24
) (
  input  logic signed [W-1:0]  x,
  input  logic signed [W-1:0]  y,
  input  logic signed [AW-1:0] hsum,
  input  logic signed [W-1:0]  recip,
  output logic signed [W-1:0]  x_next
);
  localparam int RF = W - 2;
  localparam int PW = AW + W;
  localparam int XW = PW + 1;
  localparam logic signed [XW-1:0] HI = (XW'(1) <<< (W - 1)) - XW'(1);
  localparam logic signed [XW-1:0] LO = -(XW'(1) <<< (W - 1));

  logic signed [AW-1:0] err;
  logic signed [PW-1:0] prod, corr;
  logic signed [XW-1:0] xw;

  assign err  = hsum - {{(AW-W){y[W-1]}}, y};
  assign prod = err * recip;
  assign corr = prod >>> RF;
  assign xw   = {{(XW-W){x[W-1]}}, x} - {corr[PW-1], corr};

  always_comb begin
    if (xw > HI)      x_next = HI[W-1:0];
    else if (xw < LO) x_next = LO[W-1:0];
    else              x_next = xw[W-1:0];
  end
endmodule

// File: rtl/cheb_linearizer.sv
module cheb_linearizer
  import cheb_lin_pkg::*;
#(
  parameter int W         = 16,
  parameter int MAX_ORDER = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [W-1:0]                  in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [W-1:0]                  out_data,
  input  logic                          coef_we,
  input  logic [$clog2(MAX_ORDER+1)-1:0] coef_addr,
  input  logic [W-1:0]                  coef_wdata,
  input  logic [$clog2(MAX_ORDER+1)-1:0] cfg_order,
  input  logic                          cfg_two_iter,
  input  logic [W-1:0]                  cfg_recip
);
  localparam int DEPTH = MAX_ORDER + 1;
  localparam int IW    = $clog2(DEPTH);
  localparam int F     = W - 1;
  localparam int TW    = W + 2;
  localparam int AW    = W + 8;
  localparam logic signed [TW-1:0] T_ONE = TW'(1) <<< F;

  lin_state_e          state_q, state_d;
  logic [IW-1:0]       k_q, k_d, order_q, order_d;
  logic signed [W-1:0] x_q, x_d, y_q, y_d, recip_q, recip_d;
  logic signed [TW-1:0] tcur_q, tcur_d, tprev_q, tprev_d;
  logic signed [AW-1:0] acc_q, acc_d;
  logic                iter_q, iter_d;
  logic                accept, dp_en;

  logic signed [W-1:0]  coef_rd, x_step;
  logic signed [AW-1:0] term;
  logic signed [TW-1:0] t_next;

  cheb_coef_store #(.W(W), .DEPTH(DEPTH), .IW(IW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (coef_we),
    .waddr (coef_addr),
    .wdata (coef_wdata),
    .raddr (k_q),
    .rdata (coef_rd)
  );

  cheb_term_unit #(.W(W), .TW(TW), .AW(AW)) u_term (
    .u      (x_q),
    .t_cur  (tcur_q),
    .t_prev (tprev_q),
    .first  (k_q == '0),
    .coef   (coef_rd),
    .term   (term),
    .t_next (t_next)
  );

  cheb_newton_step #(.W(W), .AW(AW)) u_step (
    .x      (x_q),
    .y      (y_q),
    .hsum   (acc_q),
    .recip  (recip_q),
    .x_next (x_step)
  );

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_OUT);
  assign out_data  = x_q;
  assign accept    = in_valid && in_ready;
  assign dp_en     = accept || (state_q == ST_EVAL) || (state_q == ST_STEP);

  always_comb begin
    state_d = state_q;
    k_d     = k_q;
    order_d = order_q;
    x_d     = x_q;
    y_d     = y_q;
    recip_d = recip_q;
    tcur_d  = tcur_q;
    tprev_d = tprev_q;
    acc_d   = acc_q;
    iter_d  = iter_q;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          x_d     = in_data;
          y_d     = in_data;
          order_d = cfg_order;
          recip_d = cfg_recip;
          iter_d  = cfg_two_iter;
          k_d     = '0;
          tcur_d  = T_ONE;
          tprev_d = '0;
          acc_d   = '0;
          state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        acc_d   = acc_q + term;
        tprev_d = tcur_q;
        tcur_d  = t_next;
        if (k_q == order_q) state_d = ST_STEP;
        else                k_d = k_q + IW'(1);
      end
      ST_STEP: begin
        x_d = x_step;
        if (iter_q) begin
          iter_d  = 1'b0;
          k_d     = '0;
          tcur_d  = T_ONE;
          tprev_d = '0;
          acc_d   = '0;
          state_d = ST_EVAL;
        end else begin
          state_d = ST_OUT;
        end
      end
      ST_OUT: begin
        if (out_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q     <= '0;
      order_q <= '0;
      x_q     <= '0;
      y_q     <= '0;
      recip_q <= '0;
      tcur_q  <= '0;
      tprev_q <= '0;
      acc_q   <= '0;
      iter_q  <= 1'b0;
    end else if (dp_en) begin
      k_q     <= k_d;
      order_q <= order_d;
      x_q     <= x_d;
      y_q     <= y_d;
      recip_q <= recip_d;
      tcur_q  <= tcur_d;
      tprev_q <= tprev_d;
      acc_q   <= acc_d;
      iter_q  <= iter_d;
    end
  end

  // R9: a result not taken stays offered, unchanged
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9: after acceptance no second sample is taken
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  // R9: a taken result frees the input side
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid);

  // R10: captured configuration does not move while a sample is in flight
  p_cfg_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != ST_IDLE |=> $stable(order_q) && $stable(recip_q));

  // R6: a final step with no pass pending presents the result next
  p_last_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_STEP && !iter_q |=> out_valid);

  // R4: the term index never passes the captured order
  p_k_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_EVAL |-> k_q <= order_q);
endmodule

// File: tb/tb_cheb_linearizer.sv
module tb_cheb_linearizer;
  localparam int  W         = 16;
  localparam int  MAX_ORDER = 7;
  localparam int  IW        = $clog2(MAX_ORDER + 1);
  localparam int  F         = W - 1;
  localparam int  CF        = W - 2;
  localparam int  RF        = W - 2;
  localparam int  TW        = W + 2;
  localparam int  AW        = W + 8;
  localparam time PERIOD    = 10ns;

  logic clk, rst_n;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [W-1:0] in_data, out_data, coef_wdata, cfg_recip;
  logic coef_we, cfg_two_iter;
  logic [IW-1:0] coef_addr, cfg_order;

  int checks = 0, failures = 0;
  bit done = 0;
  longint cm [MAX_ORDER+1];
  longint expq [$];

  cheb_linearizer #(.W(W), .MAX_ORDER(MAX_ORDER)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_wdata(coef_wdata), .cfg_order(cfg_order),
    .cfg_two_iter(cfg_two_iter), .cfg_recip(cfg_recip)
  );

  initial clk = 0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint wrapn(longint v, int n);
    longint m = longint'(1) <<< n;
    v = v & (m - 1);
    if (v >= m / 2) v = v - m;
    return v;
  endfunction

  function automatic longint sx(logic [W-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint model_h(longint x, int order);
    longint tk = longint'(1) <<< F, tkm1 = 0, acc = 0, nxt;
    for (int k = 0; k <= order; k++) begin
      acc = wrapn(acc + ((cm[k] * tk) >>> CF), AW);
      if (k == 0) nxt = x;
      else        nxt = wrapn(((2 * x * tk) >>> F) - tkm1, TW);
      tkm1 = tk;
      tk   = nxt;
    end
    return acc;
  endfunction

  function automatic longint model_fix(longint y, int order, bit two, longint r);
    longint x = y, e, xn;
    int n = two ? 2 : 1;
    for (int s = 0; s < n; s++) begin
      e  = wrapn(model_h(x, order) - y, AW);
      xn = x - ((e * r) >>> RF);
      if (xn > (longint'(1) <<< F) - 1) xn = (longint'(1) <<< F) - 1;
      if (xn < -(longint'(1) <<< F))    xn = -(longint'(1) <<< F);
      x = xn;
    end
    return x;
  endfunction

  task automatic wr_coef(input int a, input longint v);
    @(negedge clk);
    coef_we = 1; coef_addr = IW'(a); coef_wdata = W'(v);
    @(negedge clk);
    coef_we = 0;
    cm[a] = v;
  endtask

  task automatic set_cfg(input int order, input bit two, input longint r);
    cfg_order = IW'(order); cfg_two_iter = two; cfg_recip = W'(r);
  endtask

  // Sends one sample, measures latency, optionally stalls the output and
  // perturbs the configuration mid-flight, then compares against the model.
  task automatic run(input longint y, input int stall, input bit perturb, input string tag);
    int lat = 0;
    int order = int'(cfg_order);
    bit two = cfg_two_iter;
    longint r = sx(cfg_recip), got;
    logic [IW-1:0] so; logic st; logic [W-1:0] sr;
    expq.push_back(model_fix(y, order, two, r));
    @(negedge clk);
    check(in_ready === 1'b1, "R9 ready before send", in_ready, 1);
    in_valid = 1; in_data = W'(y);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_data = '0;
    so = cfg_order; st = cfg_two_iter; sr = cfg_recip;
    if (perturb) begin
      cfg_order = IW'(MAX_ORDER); cfg_two_iter = ~two; cfg_recip = W'(r / 2 + 7);
    end
    check(in_ready === 1'b0, "R9 busy after accept", in_ready, 0);
    lat = 1;
    while (out_valid !== 1'b1 && lat < 1000) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    lat = lat - 1;
    check(lat == (two ? 2 : 1) * (order + 2), {tag, " R8 latency"}, lat, (two ? 2 : 1) * (order + 2));
    got = sx(out_data);
    for (int s = 0; s < stall; s++) begin
      @(posedge clk); @(negedge clk);
      check(out_valid === 1'b1 && sx(out_data) == got && in_ready === 1'b0,
            {tag, " R9 hold under stall"}, sx(out_data), got);
    end
    if (perturb) begin
      cfg_order = so; cfg_two_iter = st; cfg_recip = sr;
    end
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    out_ready = 0;
    begin
      longint e = expq.pop_front();
      check(got == e, {tag, " result"}, got, e);
    end
    check(in_ready === 1'b1 && out_valid === 1'b0, "R9 release", out_valid, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_data = '0; out_ready = 0;
    coef_we = 0; coef_addr = '0; coef_wdata = '0;
    set_cfg(1, 0, 16384);
    for (int i = 0; i <= MAX_ORDER; i++) cm[i] = 0;
    repeat (3) @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0, "R1 reset state", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0, "R1 after release", out_valid, 0);

    // R2 R3: identity model returns the input unchanged
    wr_coef(1, 16384);
    set_cfg(1, 0, 16384);
    foreach (expq[i]) ;
    begin
      longint ys [5] = '{0, 12345, -32768, 32767, -777};
      foreach (ys[i]) begin
        run(ys[i], 0, 0, "R3 identity");
        check(model_fix(ys[i], 1, 0, 16384) == ys[i], "R3 model is identity", model_fix(ys[i], 1, 0, 16384), ys[i]);
      end
      set_cfg(1, 1, 16384);
      run(-20000, 0, 0, "R3 R6 identity two steps");
    end

    // R4 R5 R6: distorted model, order 4, one and two steps
    wr_coef(0, 120); wr_coef(1, 16100); wr_coef(2, -300);
    wr_coef(3, 180); wr_coef(4, -60);
    begin
      longint ys [6] = '{0, 9000, -9000, 25000, -31000, 32700};
      foreach (ys[i]) begin
        set_cfg(4, 0, 16673); run(ys[i], 0, 0, "R5 one step");
        set_cfg(4, 1, 16673); run(ys[i], 0, 0, "R6 two steps");
      end
    end

    // R4: full order with upper coefficients
    wr_coef(5, 45); wr_coef(6, -25); wr_coef(7, 15);
    set_cfg(7, 1, 16673);
    run(20000, 0, 0, "R4 order max");
    run(-12345, 0, 0, "R4 order max neg");

    // R4: coefficient above the order is ignored
    wr_coef(3, 30000);
    set_cfg(2, 0, 16673);
    run(15000, 0, 0, "R4 above order ignored");
    check(model_fix(15000, 2, 0, 16673) != model_fix(15000, 3, 0, 16673),
          "R4 stimulus is sensitive", 0, 1);

    // R4 R8: order 0 uses only the constant term
    set_cfg(0, 0, 16384);
    run(1000, 0, 0, "R4 order zero");

    // R7: clamp at both ends
    wr_coef(0, -8000); wr_coef(1, 16384); wr_coef(2, 0);
    set_cfg(1, 0, 16384);
    run(32000, 0, 0, "R7 clamp high");
    wr_coef(0, 8000);
    run(-32000, 0, 0, "R7 clamp low");
    set_cfg(1, 1, 16384);
    run(-32000, 0, 0, "R7 clamp low two steps");

    // R9: output stalled for several cycles
    wr_coef(0, 100);
    set_cfg(2, 1, 16000);
    run(5000, 6, 0, "R9 stall");

    // R10: configuration changed mid-flight
    wr_coef(0, 120); wr_coef(2, -300);
    set_cfg(2, 0, 16673);
    run(-4000, 2, 1, "R10 perturb");
    set_cfg(3, 1, 16000);
    run(11111, 0, 1, "R10 perturb two");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule